// File: doc/BRIEF.md
# Segmented Buffer Link Transmitter

This block sends the contents of a 2 KB transmit buffer over a serial event link as one framed burst of characters. The characters are bytes with a control flag. A control character opens the frame, and the start character also tells the receiver which of two formats follows. The data bytes come next, then a closing control character and a 16-bit checksum. The checksum is sent high byte first. The 8b10b encoder and the merging of this burst with event codes both lie downstream of this block.

There are two modes. Whole-buffer mode always reads from address 0. Segment mode treats the buffer as 128 segments of 16 bytes each. It sends a segment number after the start character and reads from that segment onward. Software can therefore refresh one segment, or a run of consecutive segments, and leave the rest of the receiver's copy untouched. Segment 127 normally carries the system's delay-compensation data. The block treats segment 127 like any other segment; a run that passes it continues from address 0.

Software sets the mode, a length counted in 4-byte units and the starting segment, then pulses the start input. The block reads the buffer through a synchronous read port with one cycle of latency. Each character is held on the output until the downstream side takes it. The running and done flags report where the transfer stands.

Top module: `seg_buf_tx`

## Requirements
- R1: After reset, tx_valid, tx_running and tx_complete are all low.
- R2: In whole-buffer mode (seg_mode=0), the frame opens with control character 0x1C (tx_k=1). It then carries 4*size_w data bytes (tx_k=0), read from ascending addresses starting at 0.
- R3: In segment mode (seg_mode=1), the frame opens with control character 0x5C. The next character is a data byte equal to seg_start. The data bytes that follow start at address 16*seg_start and run upward.
- R4: After the last data byte come control character 0x3C, then the checksum high byte, then the checksum low byte. Both checksum bytes have tx_k=0.
- R5: The checksum equals 0xFFFF minus the sum of the data bytes, taken modulo 2^16. The framing characters and the segment byte are not included.
- R6: When size_w is 0, no data bytes are sent and the checksum is 0xFFFF.
- R7: A start accepted while idle makes tx_running high on the next cycle. tx_valid is high exactly while tx_running is high.
- R8: tx_complete goes high in the cycle after the low checksum byte is accepted. It is cleared on the cycle after the next accepted start.
- R9: A start pulse while tx_running is high has no effect. The frame in progress continues unchanged, and no second frame is sent.
- R10: While tx_valid is high and tx_ready is low, tx_data and tx_k stay unchanged on the next cycle.
- R11: Buffer addresses wrap modulo the buffer size. A segment run that passes the last segment continues from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle transfer request |
| seg_mode | input | 1 | 0 = whole buffer, 1 = segment mode |
| size_w | input | SZ_W | Transfer length in 4-byte units |
| seg_start | input | SEG_W | First segment number (segment mode) |
| mem_addr | output | ADDR_W | Buffer read address |
| mem_rdata | input | 8 | Buffer read data, one cycle after address |
| tx_data | output | 8 | Character byte |
| tx_k | output | 1 | Character is a control character |
| tx_valid | output | 1 | Character present |
| tx_ready | input | 1 | Downstream accepts the character |
| tx_running | output | 1 | Transfer in progress |
| tx_complete | output | 1 | Last transfer finished |

## Verification
The checker watches several rules on every cycle. It confirms that characters are held during back-pressure and that every control character is one of the three framing codes. It also checks that a frame always opens with a start code, that tx_running rises after an accepted start, and that tx_complete is set whenever a transfer ends. Other behaviours depend on the buffer contents and on order, and only the bench's scenarios can show them. These are the exact byte order, the checksum value, the segment addressing with wrap past the reserved segment, the zero-length frame and the ignored mid-transfer start. The bench checks them against frames it predicts itself, while tx_ready is driven in irregular patterns.

// File: rtl/seg_buf_tx.sv
module seg_buf_tx #(
  parameter int ADDR_W  = 11,
  parameter int SEG_LG  = 4,
  parameter int SZ_W    = ADDR_W - 1,
  parameter int SEG_W   = ADDR_W - SEG_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              seg_mode,
  input  logic [SZ_W-1:0]   size_w,
  input  logic [SEG_W-1:0]  seg_start,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_k,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_running,
  output logic              tx_complete
);
  localparam int CNT_W = SZ_W + 2;
  localparam logic [7:0] K_WHOLE = 8'h1C;
  localparam logic [7:0] K_END   = 8'h3C;
  localparam logic [7:0] K_SEG   = 8'h5C;

  typedef enum logic [2:0] {S_IDLE, S_SOF, S_SEG, S_DATA, S_EOF, S_CKH, S_CKL} st_t;

  st_t               st;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  left;
  logic [15:0]       sum;
  logic [15:0]       chk;
  logic              mode_q;
  logic [SEG_W-1:0]  seg_q;
  logic              fire;

  assign tx_valid   = (st != S_IDLE);
  assign tx_running = tx_valid;
  assign fire       = tx_valid & tx_ready;
  assign chk        = ~sum;
  assign mem_addr   = (st == S_DATA && fire) ? ptr + 1'b1 : ptr;

  always_comb begin
    tx_k    = 1'b0;
    tx_data = 8'h00;
    case (st)
      S_SOF:  begin tx_k = 1'b1; tx_data = mode_q ? K_SEG : K_WHOLE; end
      S_SEG:  tx_data = 8'(seg_q);
      S_DATA: tx_data = mem_rdata;
      S_EOF:  begin tx_k = 1'b1; tx_data = K_END; end
      S_CKH:  tx_data = chk[15:8];
      S_CKL:  tx_data = chk[7:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ptr         <= '0;
      left        <= '0;
      sum         <= '0;
      mode_q      <= 1'b0;
      seg_q       <= '0;
      tx_complete <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st          <= S_SOF;
          mode_q      <= seg_mode;
          seg_q       <= seg_start;
          ptr         <= seg_mode ? {seg_start, {SEG_LG{1'b0}}} : '0;
          left        <= {size_w, 2'b00};
          sum         <= '0;
          tx_complete <= 1'b0;
        end
        S_SOF: if (fire)
          st <= mode_q ? S_SEG : (left == '0 ? S_EOF : S_DATA);
        S_SEG: if (fire)
          st <= (left == '0) ? S_EOF : S_DATA;
        S_DATA: if (fire) begin
          ptr  <= ptr + 1'b1;
          sum  <= sum + 16'(mem_rdata);
          left <= left - 1'b1;
          if (left == CNT_W'(1)) st <= S_EOF;
        end
        S_EOF: if (fire) st <= S_CKH;
        S_CKH: if (fire) st <= S_CKL;
        S_CKL: if (fire) begin
          st          <= S_IDLE;
          tx_complete <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module seg_buf_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] tx_data,
  input logic       tx_k,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_running,
  input logic       tx_complete
);
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_k));

  p_kcode_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_k |-> (tx_data == 8'h1C || tx_data == 8'h3C || tx_data == 8'h5C));

  p_frame_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_k && (tx_data == 8'h1C || tx_data == 8'h5C));

  p_start_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_running && start |=> tx_running && tx_valid);

  p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_running) |-> tx_complete);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_complete |-> !tx_running);
endmodule

bind seg_buf_tx seg_buf_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data), .tx_k(tx_k),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_running(tx_running),
  .tx_complete(tx_complete)
);

// File: tb/sim_seg_buf_tx.sv
module sim_seg_buf_tx;
  localparam int ADDR_W = 11;
  localparam int SZ_W   = ADDR_W - 1;
  localparam int SEG_W  = ADDR_W - 4;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic seg_mode = 1'b0;
  logic [SZ_W-1:0] size_w = '0;
  logic [SEG_W-1:0] seg_start = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_rdata;
  logic [7:0] tx_data;
  logic tx_k, tx_valid, tx_running, tx_complete;
  logic tx_ready = 1'b1;

  logic [7:0] mem [MEMSZ];
  logic [8:0] q_exp [$];
  string      q_req [$];
  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  seg_buf_tx u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_mode(seg_mode),
    .size_w(size_w), .seg_start(seg_start), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_k(tx_k),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_running(tx_running),
    .tx_complete(tx_complete)
  );

  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (ready_mode == 0) tx_ready = 1'b1;
    else if (ready_mode == 1) tx_ready = lfsr[0];
    else tx_ready = lfsr[0] & lfsr[3];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic       prev_stall = 1'b0;
  logic [8:0] prev_chr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check({tx_valid, tx_k, tx_data} == {1'b1, prev_chr}, "R10 stall hold",
              {tx_k, tx_data}, prev_chr);
      if (tx_valid && tx_ready) begin
        if (q_exp.size() == 0)
          check(1'b0, "R9 unexpected character", {tx_k, tx_data}, 0);
        else begin
          logic [8:0] e;
          string r;
          e = q_exp.pop_front();
          r = q_req.pop_front();
          check({tx_k, tx_data} == e, r, {tx_k, tx_data}, e);
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_chr = {tx_k, tx_data};
    end
  end

  task automatic push(input logic [8:0] c, input string r);
    q_exp.push_back(c);
    q_req.push_back(r);
  endtask

  task automatic run_frame(input bit m, input int sz, input int sg, input bit poke);
    logic [15:0] s;
    int base;
    s = 16'h0;
    base = m ? sg * 16 : 0;
    push(m ? 9'h15C : 9'h11C, m ? "R3 start code" : "R2 start code");
    if (m) push({1'b0, 8'(sg)}, "R3 segment byte");
    for (int i = 0; i < sz * 4; i++) begin
      logic [7:0] b;
      b = mem[(base + i) % MEMSZ];
      s = s + 16'(b);
      push({1'b0, b}, (base + i >= MEMSZ) ? "R11 wrapped data" : (m ? "R3 data" : "R2 data"));
    end
    s = 16'hFFFF - s;
    push(9'h13C, "R4 end code");
    push({1'b0, s[15:8]}, sz == 0 ? "R6 checksum high" : "R5 checksum high");
    push({1'b0, s[7:0]}, sz == 0 ? "R6 checksum low" : "R5 checksum low");
    @(posedge clk); #2;
    seg_mode = m; size_w = SZ_W'(sz); seg_start = SEG_W'(sg); start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk);
    check(tx_running && tx_valid, "R7 running after start", tx_running, 1);
    check(!tx_complete, "R8 complete cleared", tx_complete, 0);
    if (poke) begin
      repeat (3) @(posedge clk);
      #2; seg_mode = ~m; size_w = SZ_W'(1); start = 1'b1;
      @(posedge clk); #2; start = 1'b0;
    end
    while (tx_running) @(negedge clk);
    check(q_exp.size() == 0, "R9 frame length", q_exp.size(), 0);
    check(tx_complete, "R8 complete set", tx_complete, 1);
    repeat (4) @(negedge clk);
    check(!tx_valid && tx_complete, "R9 no extra frame", tx_valid, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({tx_valid, tx_running, tx_complete} == 3'b000, "R1 reset state",
          {tx_valid, tx_running, tx_complete}, 0);
    #3 rst_n = 1'b1;
    @(negedge clk);
    check({tx_valid, tx_running, tx_complete} == 3'b000, "R1 idle after reset",
          {tx_valid, tx_running, tx_complete}, 0);
    ready_mode = 0; run_frame(1'b0, 2, 0, 1'b0);
    ready_mode = 1; run_frame(1'b1, 8, 3, 1'b0);
    ready_mode = 2; run_frame(1'b0, 0, 0, 1'b0);
    ready_mode = 1; run_frame(1'b1, 0, 9, 1'b0);
    ready_mode = 2; run_frame(1'b1, 8, 127, 1'b0);
    ready_mode = 1; run_frame(1'b0, 5, 0, 1'b1);
    ready_mode = 0; run_frame(1'b1, 4, 60, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule